// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one global history register that records the outcomes of recently resolved branches. It also keeps a pattern table of 2-bit saturating counters. A fetch-stage word address is mixed with the history to pick one counter, and that counter's upper bit is the guess. An elaboration parameter chooses how the two are mixed. In the XOR mode, the address bits and the history bits are combined bit by bit at equal width. In the concatenation mode, a few address bits sit above the low history bits.

Lookup is purely combinational. The current history comes out with each prediction so that the front end can keep it as a snapshot. When the branch resolves, the back end returns the branch address, the real outcome and that snapshot. The counter picked by the address and the snapshot is trained. The history then takes in the outcome. If the update is flagged as a misprediction, the history is first reloaded from the snapshot and the outcome is shifted in after that. Instructions are word aligned, so the address ports carry only bits `IDX_W+1` down to 2; the two byte-offset bits never reach the block.

Top module: `gpred_top`

## Requirements
- R1: After reset the history output `lk_hist` is all zeros.
- R2: After reset, every table entry whose index is even holds 01 (weak not-taken) and every odd entry holds 10 (weak taken). Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken.
- R3: A valid update moves the selected counter one step up for a taken outcome and one step down for a not-taken outcome. The prediction is the counter's upper bit (1 = taken), so one contrary outcome from a strong state does not flip the prediction.
- R4: Counters saturate: a taken outcome at 11 leaves 11, and a not-taken outcome at 00 leaves 00.
- R5: A valid update without the mispredict flag shifts the history left by one and puts the outcome (1 = taken) into bit 0. The `up_hist` input has no effect in this case.
- R6: A valid update with the mispredict flag loads `{up_hist[IDX_W-2:0], up_taken}` into the history.
- R7: In XOR mode, the table index for a lookup is `lk_pc ^ history`. For an update, the index is `up_pc ^ up_hist`.
- R8: In concatenation mode with `SEL_PC_W` address bits, the index is `{pc[SEL_PC_W+1:2], hist[IDX_W-SEL_PC_W-1:0]}`. The lookup uses the current history and the update uses `up_hist`.
- R9: When an update and a lookup touch the same entry in one cycle, the lookup returns the value from before the update.
- R10: While `up_valid` is low, neither the history nor any counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | IDX_W (bits IDX_W+1:2) | Word address of the branch being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | IDX_W | Current global history, to be kept as the snapshot |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | IDX_W (bits IDX_W+1:2) | Word address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | IDX_W | History snapshot taken at prediction time |
| up_mispredict | input | 1 | The prediction was wrong; restore history from the snapshot |

## Verification
The checker watches the history register on every cycle. It confirms that the history is zero just after reset, and that it holds while no update is presented. On a correct-path update, the history must shift in the outcome. On a mispredicted update, it must be rebuilt from the snapshot. Counter training, saturation, the alternating reset pattern, and the two index functions can only be seen through the predictions. The bench's scenarios show these by steering lookups onto entries it has trained, for both index modes side by side. The bench also shows that a lookup in the same cycle as an update returns the value from before that update.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    typedef enum logic {
        IDX_XOR    = 1'b0,
        IDX_CONCAT = 1'b1
    } idx_mode_t;

    function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != CTR_ST)
            nxt = ctr_t'(cur + 2'b01);
        else if (!taken && cur != CTR_SNT)
            nxt = ctr_t'(cur - 2'b01);
        return nxt;
    endfunction

    function automatic ctr_t ctr_init(input logic odd);
        return odd ? CTR_WT : CTR_WNT;
    endfunction

endpackage

// File: rtl/gpred_index.sv
module gpred_index
    import gpred_pkg::*;
#(
    parameter int        IDX_W    = 10,
    parameter int        SEL_PC_W = 4,
    parameter idx_mode_t MODE     = IDX_XOR
) (
    input  logic [IDX_W+1:2]  pc,
    input  logic [IDX_W-1:0]  hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int HIST_KEEP = IDX_W - SEL_PC_W;

    generate
        if (MODE == IDX_XOR) begin : g_xor
            assign idx = pc ^ hist;
        end else begin : g_cat
            assign idx = {pc[SEL_PC_W+1:2], hist[HIST_KEEP-1:0]};
        end
    endgenerate
endmodule

// File: rtl/gpred_history.sv
module gpred_history #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             restore,
    input  logic [IDX_W-1:0] snap,
    input  logic             outcome,
    output logic [IDX_W-1:0] hist
);
    logic [IDX_W-1:0] base;

    always_comb begin
        base = restore ? snap : hist;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (shift_en)
            hist <= {base[IDX_W-2:0], outcome};
    end
endmodule

// File: rtl/gpred_pht.sv
module gpred_pht
    import gpred_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t tbl [ENTRIES];

    always_comb begin
        rd_ctr = tbl[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= ctr_init(i[0]);
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_train(tbl[wr_idx], wr_taken);
        end
    end
endmodule

// File: rtl/gpred_top.sv
module gpred_top
    import gpred_pkg::*;
#(
    parameter int        IDX_W    = 10,
    parameter int        SEL_PC_W = 4,
    parameter idx_mode_t MODE     = IDX_XOR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W+1:2] lk_pc,
    output logic             lk_taken,
    output logic [IDX_W-1:0] lk_hist,
    input  logic             up_valid,
    input  logic [IDX_W+1:2] up_pc,
    input  logic             up_taken,
    input  logic [IDX_W-1:0] up_hist,
    input  logic             up_mispredict
);
    logic [IDX_W-1:0] hist_q;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    ctr_t             lk_ctr;

    gpred_history #(.IDX_W(IDX_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (up_valid),
        .restore  (up_mispredict),
        .snap     (up_hist),
        .outcome  (up_taken),
        .hist     (hist_q)
    );

    gpred_index #(.IDX_W(IDX_W), .SEL_PC_W(SEL_PC_W), .MODE(MODE)) u_lk_idx (
        .pc   (lk_pc),
        .hist (hist_q),
        .idx  (lk_idx)
    );

    gpred_index #(.IDX_W(IDX_W), .SEL_PC_W(SEL_PC_W), .MODE(MODE)) u_up_idx (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (up_idx)
    );

    gpred_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    assign lk_taken = lk_ctr[1];
    assign lk_hist  = hist_q;
endmodule

// File: rtl/gpred_checker.sv
module gpred_checker #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             up_valid,
    input logic             up_taken,
    input logic             up_mispredict,
    input logic [IDX_W-1:0] up_hist,
    input logic [IDX_W-1:0] lk_hist
);
    p_hist_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> lk_hist == '0);

    p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_mispredict) |=>
            lk_hist == {$past(lk_hist[IDX_W-2:0]), $past(up_taken)});

    p_hist_restore_r6: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_mispredict) |=>
            lk_hist == {$past(up_hist[IDX_W-2:0]), $past(up_taken)});

    p_hist_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(lk_hist));
endmodule

bind gpred_top gpred_checker #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .up_valid      (up_valid),
    .up_taken      (up_taken),
    .up_mispredict (up_mispredict),
    .up_hist       (up_hist),
    .lk_hist       (lk_hist)
);

// File: tb/tb_gpred_top.sv
module tb_gpred_top;
    import gpred_pkg::*;

    localparam int W   = 10;
    localparam int SEL = 4;
    localparam int N   = 1 << W;

    typedef struct {
        logic         exp_x;
        logic         exp_c;
        logic [W-1:0] exp_h;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W+1:2] lk_pc = '0;
    logic         lk_taken_x, lk_taken_c;
    logic [W-1:0] lk_hist_x, lk_hist_c;
    logic         up_valid = 1'b0;
    logic [W+1:2] up_pc = '0;
    logic         up_taken = 1'b0;
    logic [W-1:0] up_hist = '0;
    logic         up_mispredict = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    item_t sb[$];

    logic [1:0]   m_x [N];
    logic [1:0]   m_c [N];
    logic [W-1:0] m_h;

    always #10 clk = ~clk;

    gpred_top #(.IDX_W(W), .SEL_PC_W(SEL), .MODE(IDX_XOR)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken_x), .lk_hist(lk_hist_x),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
        .up_mispredict(up_mispredict)
    );

    gpred_top #(.IDX_W(W), .SEL_PC_W(SEL), .MODE(IDX_CONCAT)) dut_cat (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken_c), .lk_hist(lk_hist_c),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
        .up_mispredict(up_mispredict)
    );

    function automatic logic [W-1:0] ix_x(logic [W-1:0] pc, logic [W-1:0] h);
        return pc ^ h;
    endfunction

    function automatic logic [W-1:0] ix_c(logic [W-1:0] pc, logic [W-1:0] h);
        return {pc[SEL-1:0], h[W-SEL-1:0]};
    endfunction

    function automatic logic [1:0] sat(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    function automatic item_t expect_now(logic [W-1:0] pc, string tag);
        item_t it;
        it.exp_x = m_x[ix_x(pc, m_h)][1];
        it.exp_c = m_c[ix_c(pc, m_h)][1];
        it.exp_h = m_h;
        it.tag   = tag;
        return it;
    endfunction

    task automatic report(logic [31:0] got, logic [31:0] exp, string what, string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            report({31'd0, lk_taken_x}, {31'd0, it.exp_x}, "xor-mode prediction", it.tag);
            report({31'd0, lk_taken_c}, {31'd0, it.exp_c}, "concat-mode prediction", it.tag);
            report({22'd0, lk_hist_x}, {22'd0, it.exp_h}, "history", it.tag);
        end
    end

    task automatic probe(logic [W-1:0] pc, string tag);
        @(posedge clk); #2;
        up_valid = 1'b0;
        lk_pc    = pc;
        sb.push_back(expect_now(pc, tag));
        @(negedge clk);
    endtask

    // update plus a same-cycle lookup that must see pre-update state (R9)
    task automatic upd(logic [W-1:0] pc, logic t, logic [W-1:0] snap, logic mis);
        @(posedge clk); #2;
        up_valid      = 1'b1;
        up_pc         = pc;
        up_taken      = t;
        up_hist       = snap;
        up_mispredict = mis;
        lk_pc         = ix_x(pc, snap) ^ m_h;
        sb.push_back(expect_now(lk_pc, "R9"));
        m_x[ix_x(pc, snap)] = sat(m_x[ix_x(pc, snap)], t);
        m_c[ix_c(pc, snap)] = sat(m_c[ix_c(pc, snap)], t);
        m_h = mis ? {snap[W-2:0], t} : {m_h[W-2:0], t};
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_x[i] = i[0] ? 2'b10 : 2'b01;
            m_c[i] = i[0] ? 2'b10 : 2'b01;
        end
        m_h = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);

        // R1 reset history
        report({22'd0, lk_hist_x}, 32'd0, "history after reset", "R1");
        // R2 alternating reset pattern, R8 concat index differs from xor
        probe(10'd0, "R2");
        probe(10'd1, "R2");
        probe(10'd2, "R2 R8");
        probe(10'd3, "R2 R8");
        @(posedge clk); #2; lk_pc = 10'd1;
        @(negedge clk);
        report({31'd0, lk_taken_x}, 32'd1, "odd entry weak taken", "R2");
        report({31'd0, lk_taken_c}, 32'd0, "concat idx 64 weak not-taken", "R8");

        // R3 / R4 training and saturation on entry 6 (snapshot 0)
        repeat (3) upd(10'd6, 1'b1, '0, 1'b0);
        probe(10'd6 ^ m_h, "R4");
        upd(10'd6, 1'b0, '0, 1'b0);
        probe(10'd6 ^ m_h, "R3");
        @(posedge clk); #2; lk_pc = 10'd6 ^ m_h;
        @(negedge clk);
        report({31'd0, lk_taken_x}, 32'd1, "strong taken survives one not-taken", "R3");
        upd(10'd6, 1'b0, '0, 1'b0);
        probe(10'd6 ^ m_h, "R3");
        repeat (3) upd(10'd6, 1'b0, '0, 1'b0);
        upd(10'd6, 1'b1, '0, 1'b0);
        probe(10'd6 ^ m_h, "R4");
        @(posedge clk); #2; lk_pc = 10'd6 ^ m_h;
        @(negedge clk);
        report({31'd0, lk_taken_x}, 32'd0, "floor saturation", "R4");

        // R6 restore from snapshot
        upd(10'd9, 1'b0, 10'h155, 1'b1);
        probe(10'd9, "R6");
        report({22'd0, lk_hist_x}, 32'h2AA, "history after restore", "R6");
        // R5 snapshot ignored without mispredict
        upd(10'd9, 1'b1, 10'h000, 1'b0);
        probe(10'd9, "R5");
        report({22'd0, lk_hist_x}, 32'h155, "history after shift", "R5");

        // R10 no update when valid low
        @(posedge clk); #2;
        up_valid = 1'b0; up_pc = 10'h3C1; up_taken = 1'b1;
        up_hist = 10'h3FF; up_mispredict = 1'b1; lk_pc = 10'h3C1 ^ m_h;
        @(posedge clk); #2;
        @(negedge clk);
        report({22'd0, lk_hist_x}, 32'h155, "history held", "R10");
        probe(10'h3C1 ^ m_h, "R10");
        probe(10'h3FF, "R10");

        // R7 / R8 mixed traffic checked against the reference model
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] pc;
            pc = 10'($urandom_range(0, 31));
            upd(pc, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0) ? 10'($urandom) : m_h,
                1'($urandom_range(0, 3) == 0));
            probe(pc, "R7 R8");
        end
        for (int k = 0; k < 32; k++)
            probe(10'(k), "R7 R8");

        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule